// File: doc/BRIEF.md
# Oscillator startup trim sequencer

This block orders the start of a crystal oscillator. A free-running prescaler divides the slow RC clock, which also clocks the block, into coarse ticks. When the oscillator enable rises, the sequencer first waits a programmable number of ticks. It then drives the stored frequency trim word onto its trim output. Next it waits a second programmable number of ticks, and finally it raises a settled flag. Dropping the enable at any point returns the sequencer to rest. At rest the trim output is forced to zero and the settled flag is cleared.

The ticks are not aligned to the enable edge. A delay field of N therefore gives a wait of more than N-1 and at most N tick periods, and a field of zero skips that wait entirely. The two 4-bit delay fields are loaded together through a configuration write strobe. The trim word is loaded through its own write strobe. Status consists of the settled flag and a trim-ready flag, which is high whenever the driven trim equals the stored one. The trim word is a plain digital value; the analog side is not modelled.

Top module: `osc_trim_seq`

## Requirements
- R1: The prescaler produces one tick every TICK_DIV clocks (default 4000), counted from reset and never restarted by the enable. Every delay is therefore measured against a free-running tick grid.
- R2: After reset the first delay field holds 10 and the second holds 2. A cycle with `cfg_we` high loads both fields from `cfg_trim_dly` and `cfg_settle_dly`, and the new values take effect from the next sequence.
- R3: The first delay is counted from the edge at which a rising `osc_en` is seen. With a field value of 0, `trim_out` takes the stored value 2 clocks after that edge. With a value N≥1, it does so between (N-1)·TICK_DIV+3 and N·TICK_DIV+2 clocks after it.
- R4: The second delay is counted from the cycle in which `trim_out` takes the stored value. With a field value of 0, `settled` rises in that same cycle. With a value M≥1, it rises between (M-1)·TICK_DIV+1 and M·TICK_DIV clocks later.
- R5: `settled` is 0 after reset. It is high only after both waits of the current enable period have completed.
- R6: `trim_ready` is 1 after reset, where `trim_out` and the stored trim are both zero. In every cycle it is 1 exactly when `trim_out` equals the stored trim word.
- R7: While `osc_en` is low, and one clock after it falls, `trim_out` is zero and `settled` is low.
- R8: A trim write while settled reaches `trim_out` within one clock and `trim_ready` returns to 1. `settled` stays high throughout.
- R9: A trim write made during the first wait is the value that is applied when that wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC reference clock; also clocks the sequencer |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator enable; a rising level starts the sequence |
| cfg_we | input | 1 | Loads both delay fields |
| cfg_trim_dly | input | DLY_W (4) | Ticks to wait before applying trim |
| cfg_settle_dly | input | DLY_W (4) | Ticks to wait after trim before settled |
| trim_we | input | 1 | Loads the stored trim word |
| trim_wdata | input | TRIM_W (8) | New stored trim word |
| trim_out | output | TRIM_W (8) | Trim word driven to the oscillator |
| settled | output | 1 | Sequence complete |
| trim_ready | output | 1 | Driven trim equals stored trim |

## Verification
Applying the trim and raising settled can fall in the same clock. This happens when the second delay field is zero, and the bench provokes it by running sequences with settle delays of 0 and first delays of 0 and 15. A behavioural model predicts each cycle and is compared on every clock. For the case with no settle delay, the bench also requires that the cycle index at which trim is seen equals the one at which settled is seen. A second collision, a trim write in the same cycle as the enable drop, is judged by requiring zero trim and a low settled flag one clock later.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

   typedef enum logic [2:0] {
      ST_IDLE        = 3'd0,
      ST_WAIT_TRIM   = 3'd1,
      ST_APPLY       = 3'd2,
      ST_WAIT_SETTLE = 3'd3,
      ST_SETTLED     = 3'd4
   } seq_state_e;

endpackage

// File: rtl/osc_tick_div.sv
module osc_tick_div #(
   parameter int DIV = 4000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("osc_tick_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/osc_delay_cnt.sv
module osc_delay_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   input  logic         tick,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (run && tick)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire = run && tick && (cnt_q == W'(1));
endmodule

// File: rtl/osc_trim_drive.sv
module osc_trim_drive
   import osc_trim_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  seq_state_e    state,
   input  logic [TW-1:0] stored,
   output logic [TW-1:0] drive
);
   logic rest, follow;

   assign rest   = !en || (state == ST_IDLE) || (state == ST_WAIT_TRIM);
   assign follow = (state == ST_APPLY) || (state == ST_SETTLED);

   always_ff @(posedge clk) begin
      if (!rst_n)       drive <= '0;
      else if (rest)    drive <= '0;
      else if (follow)  drive <= stored;
   end
endmodule

// File: rtl/osc_trim_seq.sv
module osc_trim_seq
   import osc_trim_pkg::*;
#(
   parameter int TICK_DIV       = 4000,
   parameter int TRIM_W         = 8,
   parameter int DLY_W          = 4,
   parameter int TRIM_DLY_RST   = 10,
   parameter int SETTLE_DLY_RST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_en,
   input  logic              cfg_we,
   input  logic [DLY_W-1:0]  cfg_trim_dly,
   input  logic [DLY_W-1:0]  cfg_settle_dly,
   input  logic              trim_we,
   input  logic [TRIM_W-1:0] trim_wdata,
   output logic [TRIM_W-1:0] trim_out,
   output logic              settled,
   output logic              trim_ready
);
   localparam int DLY_MAX = (1 << DLY_W) - 1;

   generate
      if (TRIM_W < 1) begin : g_bad_tw
         $error("osc_trim_seq: TRIM_W must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dw
         $error("osc_trim_seq: DLY_W must be at least 1");
      end
      if (TRIM_DLY_RST > DLY_MAX || SETTLE_DLY_RST > DLY_MAX) begin : g_bad_rst
         $error("osc_trim_seq: delay reset value exceeds field width");
      end
   endgenerate

   logic [DLY_W-1:0]  trim_dly_q, settle_dly_q;
   logic [TRIM_W-1:0] trim_reg_q;
   seq_state_e        st_q, st_d;
   logic              tick, expire, load;
   logic [DLY_W-1:0]  load_val;
   logic              run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trim_dly_q   <= DLY_W'(TRIM_DLY_RST);
         settle_dly_q <= DLY_W'(SETTLE_DLY_RST);
         trim_reg_q   <= '0;
      end else begin
         if (cfg_we) begin
            trim_dly_q   <= cfg_trim_dly;
            settle_dly_q <= cfg_settle_dly;
         end
         if (trim_we) trim_reg_q <= trim_wdata;
      end
   end

   osc_tick_div #(.DIV(TICK_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   assign run = (st_q == ST_WAIT_TRIM) || (st_q == ST_WAIT_SETTLE);

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = trim_dly_q;
      if (!osc_en) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (trim_dly_q == '0) st_d = ST_APPLY;
               else begin
                  st_d = ST_WAIT_TRIM;
                  load = 1'b1;
               end
            end
            ST_WAIT_TRIM:   if (expire) st_d = ST_APPLY;
            ST_APPLY: begin
               load_val = settle_dly_q;
               if (settle_dly_q == '0) st_d = ST_SETTLED;
               else begin
                  st_d = ST_WAIT_SETTLE;
                  load = 1'b1;
               end
            end
            ST_WAIT_SETTLE: if (expire) st_d = ST_SETTLED;
            ST_SETTLED:     st_d = ST_SETTLED;
            default:        st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   osc_delay_cnt #(.W(DLY_W)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(load_val),
      .run     (run),
      .tick    (tick),
      .expire  (expire)
   );

   osc_trim_drive #(.TW(TRIM_W)) u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (osc_en),
      .state (st_q),
      .stored(trim_reg_q),
      .drive (trim_out)
   );

   assign settled    = (st_q == ST_SETTLED);
   assign trim_ready = (trim_out == trim_reg_q);
endmodule

// File: rtl/osc_trim_seq_chk.sv
module osc_trim_seq_chk #(
   parameter int TW  = 8,
   parameter int DIV = 4000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          osc_en,
   input logic          trim_we,
   input logic [TW-1:0] trim_out,
   input logic          settled,
   input logic          trim_ready,
   input logic          tick
);
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      ((DIV > 1) && tick) |=> !tick);  // R1

   AST_SETTLED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> $past(osc_en));  // R5

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> (!settled && trim_out == '0));  // R7

   AST_SETTLED_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && $past(settled) && !$past(trim_we)) |-> trim_ready);  // R8

   AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && osc_en) |=> settled);  // R8
endmodule

bind osc_trim_seq osc_trim_seq_chk #(.TW(TRIM_W), .DIV(TICK_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_en    (osc_en),
   .trim_we   (trim_we),
   .trim_out  (trim_out),
   .settled   (settled),
   .trim_ready(trim_ready),
   .tick      (tick)
);

// File: tb/osc_trim_seq_tb.sv
module osc_trim_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 8;
   localparam int TW         = 8;
   localparam int DW         = 4;
   localparam int WATCHDOG   = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_en = 1'b0;
   logic          cfg_we = 1'b0;
   logic [DW-1:0] cfg_trim_dly = '0;
   logic [DW-1:0] cfg_settle_dly = '0;
   logic          trim_we = 1'b0;
   logic [TW-1:0] trim_wdata = '0;
   logic [TW-1:0] trim_out;
   logic          settled;
   logic          trim_ready;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   osc_trim_seq #(.TICK_DIV(DIV), .TRIM_W(TW), .DLY_W(DW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .osc_en        (osc_en),
      .cfg_we        (cfg_we),
      .cfg_trim_dly  (cfg_trim_dly),
      .cfg_settle_dly(cfg_settle_dly),
      .trim_we       (trim_we),
      .trim_wdata    (trim_wdata),
      .trim_out      (trim_out),
      .settled       (settled),
      .trim_ready    (trim_ready)
   );

   // behavioural reference: phase of the tick grid, mode 0..4, ticks left
   int            m_ph, m_mode, m_left, m_td, m_sd;
   logic [TW-1:0] m_reg, m_out;
   bit            m_tick;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_mode <= 0; m_left <= 0;
         m_td <= 10; m_sd <= 2; m_reg <= '0; m_out <= '0;
      end else begin
         m_tick = (m_ph == DIV - 1);
         m_ph <= m_tick ? 0 : m_ph + 1;
         if (!osc_en || m_mode == 0 || m_mode == 1) m_out <= '0;
         else if (m_mode == 2 || m_mode == 4) m_out <= m_reg;
         if (!osc_en) m_mode <= 0;
         else if (m_mode == 0) begin
            if (m_td == 0) m_mode <= 2;
            else begin m_mode <= 1; m_left <= m_td; end
         end else if (m_mode == 2) begin
            if (m_sd == 0) m_mode <= 4;
            else begin m_mode <= 3; m_left <= m_sd; end
         end else if ((m_mode == 1 || m_mode == 3) && m_tick) begin
            if (m_left == 1) m_mode <= m_mode + 1;
            else m_left <= m_left - 1;
         end
         if (cfg_we) begin m_td <= int'(cfg_trim_dly); m_sd <= int'(cfg_settle_dly); end
         if (trim_we) m_reg <= trim_wdata;
      end
   end

   // per-cycle comparison, R1 R5 R6 R9
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (trim_out !== m_out || settled !== (m_mode == 4) ||
             trim_ready !== (m_out == m_reg)) begin
            errors++;
            $display("FAIL R1/R5/R6/R9 cycle %0d: out=%h settled=%b ready=%b expected out=%h settled=%b ready=%b",
                     cyc, trim_out, settled, trim_ready, m_out, (m_mode == 4), (m_out == m_reg));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WATCHDOG && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: %0d cycles, expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk_range(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic chk_val(input string tag, input int act, input int exp);
      chk_range(tag, act, exp, exp);
   endtask

   task automatic write_cfg(input int td, input int sd);
      @(negedge clk);
      cfg_we = 1'b1; cfg_trim_dly = DW'(td); cfg_settle_dly = DW'(sd);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_trim(input logic [TW-1:0] v);
      @(negedge clk);
      trim_we = 1'b1; trim_wdata = v;
      @(negedge clk);
      trim_we = 1'b0;
   endtask

   // raise enable, then measure when trim appears and when settled rises
   task automatic run_seq(input int td, input int sd, input int skew, input logic [TW-1:0] v);
      int n, t_app, t_set;
      write_trim(v);
      repeat (skew) @(negedge clk);
      osc_en = 1'b1;
      n = 0; t_app = -1; t_set = -1;
      while (t_set < 0 && n < 400) begin
         @(negedge clk);
         n++;
         if (t_app < 0 && trim_out == v) t_app = n;
         if (t_set < 0 && settled) t_set = n;
      end
      if (td == 0) chk_val($sformatf("R3 trim delay %0d", td), t_app, 2);
      else chk_range($sformatf("R3 trim delay %0d", td), t_app, (td - 1) * DIV + 3, td * DIV + 2);
      if (sd == 0) chk_val($sformatf("R4 settle delay %0d", sd), t_set - t_app, 0);
      else chk_range($sformatf("R4 settle delay %0d", sd), t_set - t_app, (sd - 1) * DIV + 1, sd * DIV);
   endtask

   task automatic drop_en;
      @(negedge clk);
      osc_en = 1'b0;
      @(negedge clk);
      chk_val("R7 trim_out zero after disable", int'(trim_out), 0);
      chk_val("R7 settled low after disable", int'(settled), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk_val("R5 settled reset", int'(settled), 0);
      chk_val("R6 trim_ready reset", int'(trim_ready), 1);
      chk_val("R7 trim_out reset", int'(trim_out), 0);
      rst_n = 1'b1;

      // R2: reset delay values 10 and 2 (no configuration write)
      run_seq(10, 2, 3, 8'h5A);
      drop_en();

      write_cfg(0, 0);  run_seq(0, 0, 1, 8'h11);  drop_en();
      write_cfg(1, 1);  run_seq(1, 1, 2, 8'h22);  drop_en();
      write_cfg(1, 1);  run_seq(1, 1, 6, 8'h23);  drop_en();
      write_cfg(2, 2);  run_seq(2, 2, 5, 8'h33);  drop_en();
      write_cfg(15, 15); run_seq(15, 15, 0, 8'h44); drop_en();
      write_cfg(0, 15); run_seq(0, 15, 4, 8'h55);  drop_en();
      write_cfg(15, 0); run_seq(15, 0, 7, 8'h66);  drop_en();
      write_cfg(2, 1);  run_seq(2, 1, 3, 8'h77);

      // R8: trim update while settled
      @(negedge clk);
      trim_we = 1'b1; trim_wdata = 8'h9C;
      @(negedge clk);
      trim_we = 1'b0;
      @(negedge clk);
      chk_val("R8 trim follows", int'(trim_out), 'h9C);
      chk_val("R8 trim_ready back", int'(trim_ready), 1);
      chk_val("R8 settled stays", int'(settled), 1);

      // R7: trim write in the same cycle as the enable drop
      @(negedge clk);
      trim_we = 1'b1; trim_wdata = 8'hE1; osc_en = 1'b0;
      @(negedge clk);
      trim_we = 1'b0;
      chk_val("R7 zero trim on drop with write", int'(trim_out), 0);
      chk_val("R7 settled low on drop with write", int'(settled), 0);
      chk_val("R6 ready low while trim differs", int'(trim_ready), 0);

      // R9: trim written during the first wait is the one applied
      write_cfg(3, 0);
      write_trim(8'h10);
      @(negedge clk);
      osc_en = 1'b1;
      repeat (3) @(negedge clk);
      trim_we = 1'b1; trim_wdata = 8'hB7;
      @(negedge clk);
      trim_we = 1'b0;
      repeat (3 * DIV + 4) @(negedge clk);
      chk_val("R9 late trim applied", int'(trim_out), 'hB7);
      chk_val("R9 settled after late trim", int'(settled), 1);
      drop_en();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule